// File: doc/BRIEF.md
# Power Management Status Register Bank

This block is a single 8-bit control and status register for a power-management controller. It has one read/write field and four sticky event flags. The field is a 2-bit selector for the minimum processor PLL lock wait. The flags record a press of the system reset button, a processor thermal trip, a too-short sleep-signal assertion reported by a separate width checker, and a failure of the processor supply regulator. Each flag has its own set condition and its own way of being cleared by software. The bank sits in several reset domains at once: a resume-well reset, a core-well reset class, and a software-requested full reset. Each bit is cleared only by the resets that apply to it.

The regulator power-good input is sampled on the slow real-time clock. That sample is passed into the register clock domain through a synchroniser whose depth is a parameter. A high-to-low transition seen after the synchroniser counts as a supply failure while the system is awake. The address decode is reduced to a single select input. Read data is combinational and always shows the packed register. A separate override selection, driven from outside the bank, can replace the lock-time code on the effective-selection output.

Top module: `pm_status_bank`

## Requirements
- R1: After the resume-well reset (`rsm_rst_n` low at a clock edge), `reg_rdata` reads 0x00, and `lock_sel_o` reads 0 while the override is off.
- R2: The lock-time field is `reg_rdata[1:0]`, with codes 0 to 3 selecting minimum waits of 30.7, 61.4, 122.8 and 245.6 us. A selected write loads it from `reg_wdata[1:0]`. Only the resume-well reset or `sw_full_rst` clears it to 0. The core-well reset leaves it unchanged.
- R3: While `lock_ovr_en` is 1, `lock_sel_o` equals `lock_ovr_code`. Otherwise it equals the lock-time field. The override never changes `reg_rdata[1:0]`.
- R4: The reset-button flag (`reg_rdata[2]`) sets one cycle after `rst_button` is high. A selected write with bit 2 = 1 clears it. The resume-well reset and `sw_full_rst` clear it. The core-well reset does not.
- R5: The thermal flag (`reg_rdata[3]`) sets one cycle after `therm_trip` is high while `plt_rst_n` is high and `sleep_state` is S0 (code 0) or S1 (code 1). It does not set for any other combination. A selected write with bit 3 = 1 clears it.
- R6: The thermal flag survives an assertion of `plt_rst_n` (the shutdown and reboot after a trip). It is cleared by `core_rst_n` low, by the resume-well reset and by `sw_full_rst`.
- R7: The width-violation flag (`reg_rdata[4]`) sets one cycle after a `width_viol` pulse. A selected write with bit 4 = 1 clears it. Only the resume-well reset clears it among the resets.
- R8: The supply-failure flag (`reg_rdata[5]`) sets when the real-time-clock sample of `vrm_pgood`, after the synchroniser, goes from 1 to 0 while `sleep_state` is S0 or S1. A low level entered in another state does not set it. A selected write with bit 5 = 0 clears it, while bit 5 = 1 leaves it set. Only the resume-well reset clears it among the resets.
- R9: A low pulse on `vrm_pgood` that begins and ends between two rising edges of `rtc_clk` never sets the supply-failure flag.
- R10: When a hardware set and a software clear reach the same flag in the same cycle, the flag ends up set.
- R11: `reg_rdata[7:6]` always read 0, and writes to those bits have no effect.
- R12: A write with `reg_sel` low changes no bit of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rtc_clk | input | 1 | Slow real-time clock that samples the power-good input |
| rsm_rst_n | input | 1 | Resume-well reset, synchronous, active low |
| core_rst_n | input | 1 | Core-well reset class, synchronous, active low |
| sw_full_rst | input | 1 | Software-requested full reset, one-cycle pulse, active high |
| reg_sel | input | 1 | Address match for this register |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Packed register contents |
| lock_ovr_en | input | 1 | Override of the lock-time selection is programmed |
| lock_ovr_code | input | 2 | Override lock-time code |
| lock_sel_o | output | 2 | Effective lock-time selection |
| rst_button | input | 1 | System reset button pressed |
| plt_rst_n | input | 1 | Platform reset, active low |
| therm_trip | input | 1 | Processor thermal trip, active high |
| sleep_state | input | 3 | Current sleep state code (0 = S0, 1 = S1, 3 = S3, 4 = S4, 5 = S5) |
| width_viol | input | 1 | Pulse from the sleep-signal width checker |
| vrm_pgood | input | 1 | Regulator power-good, sampled on `rtc_clk` |

## Verification
The bench builds the bank with a three-stage synchroniser instead of the default two. This lengthens the path from a real-time-clock sample to the flag and shows that the reference model's delay queue follows the parameter, not a fixed latency. The real-time clock runs at one eighth of the register clock, with edges offset from it. This allows low pulses to be placed strictly between two slow-clock samples, and long lows that cross several samples, so both the missed-glitch case and the detected-failure case are exercised.

// File: rtl/pm_status_pkg.sv
// Shared encodings for the power-management status bank.
// Assumes sleep states are carried as a 3-bit code on the input.
package pm_status_pkg;

    typedef enum logic [2:0] {
        SLP_S0 = 3'd0,
        SLP_S1 = 3'd1,
        SLP_S3 = 3'd3,
        SLP_S4 = 3'd4,
        SLP_S5 = 3'd5
    } sleep_e;

    // True for the awake states in which thermal and supply events count.
    function automatic logic is_awake(input logic [2:0] code);
        return (code == SLP_S0) || (code == SLP_S1);
    endfunction

endpackage

// File: rtl/pm_rtc_pgood_sync.sv
// Samples regulator power-good on the real-time clock, carries the sample
// into the register clock domain through SYNC_STAGES flops, and flags a
// one-cycle pulse when the synchronised level drops from 1 to 0.
// Assumes rsm_rst_n stays low across at least one rtc_clk rising edge.
module pm_rtc_pgood_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rtc_clk,
    input  logic rsm_rst_n,
    input  logic pgood_i,
    output logic fall_o
);

    logic                   rtc_q;
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;

    // Slow-clock sample of power-good; resets to "good" to avoid a false fall.
    always_ff @(posedge rtc_clk) begin
        if (!rsm_rst_n) rtc_q <= 1'b1;
        else            rtc_q <= pgood_i;
    end

    // Synchroniser chain into the register domain.
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rsm_rst_n) chain_q[0] <= 1'b1;
                else            chain_q[0] <= rtc_q;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rsm_rst_n) chain_q[s] <= 1'b1;
                else            chain_q[s] <= chain_q[s-1];
            end
        end
    end

    // Previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rsm_rst_n) last_q <= 1'b1;
        else            last_q <= chain_q[SYNC_STAGES-1];
    end

    assign fall_o = last_q & ~chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/pm_sticky_flag.sv
// One sticky status bit. A hardware set wins over a software clear; the
// clear fires when a selected write carries CLR_ON_ONE in this bit position.
// clr_n is the combined synchronous reset for this bit's domain.
module pm_sticky_flag #(
    parameter bit CLR_ON_ONE = 1'b1
) (
    input  logic clk,
    input  logic clr_n,
    input  logic set_i,
    input  logic wr_i,
    input  logic wr_bit_i,
    output logic flag_o
);

    // Reset first, then set, then software clear.
    always_ff @(posedge clk) begin
        if (!clr_n)                              flag_o <= 1'b0;
        else if (set_i)                          flag_o <= 1'b1;
        else if (wr_i && (wr_bit_i == CLR_ON_ONE)) flag_o <= 1'b0;
    end

endmodule

// File: rtl/pm_lock_field.sv
// Read/write lock-time selector plus the override mux that produces the
// effective selection. clr_n combines only the resets that reach this field.
module pm_lock_field #(
    parameter int LOCK_W = 2
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              wr_i,
    input  logic [LOCK_W-1:0] wdata_i,
    input  logic              ovr_en_i,
    input  logic [LOCK_W-1:0] ovr_code_i,
    output logic [LOCK_W-1:0] field_o,
    output logic [LOCK_W-1:0] eff_o
);

    // Software-programmed lock-time code.
    always_ff @(posedge clk) begin
        if (!clr_n)    field_o <= '0;
        else if (wr_i) field_o <= wdata_i;
    end

    // Override takes precedence when programmed.
    always_comb begin
        eff_o = ovr_en_i ? ovr_code_i : field_o;
    end

endmodule

// File: rtl/pm_status_bank.sv
// Power-management status register bank: lock-time selector and four sticky
// event flags, each in its own reset domain. Register layout:
// [1:0] lock code, [2] button, [3] thermal, [4] width, [5] supply, rest 0.
// Assumes all resets are synchronous to clk and that reg_sel is the decode
// of this single register address.
module pm_status_bank
    import pm_status_pkg::*;
#(
    parameter int REG_W       = 8,
    parameter int LOCK_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rtc_clk,
    input  logic              rsm_rst_n,
    input  logic              core_rst_n,
    input  logic              sw_full_rst,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              lock_ovr_en,
    input  logic [LOCK_W-1:0] lock_ovr_code,
    output logic [LOCK_W-1:0] lock_sel_o,
    input  logic              rst_button,
    input  logic              plt_rst_n,
    input  logic              therm_trip,
    input  logic [2:0]        sleep_state,
    input  logic              width_viol,
    input  logic              vrm_pgood
);

    localparam int N_FLAGS  = 4;
    localparam int FLAG_LSB = LOCK_W;
    localparam int USED_W   = FLAG_LSB + N_FLAGS;
    // Flag order: 0 button, 1 thermal, 2 width, 3 supply (clears on 0).
    localparam logic [N_FLAGS-1:0] CLR_ONE_MASK = 4'b0111;

    logic                wr_hit;
    logic                awake;
    logic                pgood_fall;
    logic [LOCK_W-1:0]   lock_field;
    logic [N_FLAGS-1:0]  set_vec;
    logic [N_FLAGS-1:0]  clr_n_vec;
    logic [N_FLAGS-1:0]  flag_vec;
    logic                unused_wdata;

    assign wr_hit       = reg_wr & reg_sel;
    assign awake        = is_awake(sleep_state);
    assign unused_wdata = ^reg_wdata[REG_W-1:USED_W];

    // Hardware set conditions per flag.
    always_comb begin
        set_vec[0] = rst_button;
        set_vec[1] = plt_rst_n & therm_trip & awake;
        set_vec[2] = width_viol;
        set_vec[3] = pgood_fall & awake;
    end

    // Reset domain of each flag.
    always_comb begin
        clr_n_vec[0] = rsm_rst_n & ~sw_full_rst;
        clr_n_vec[1] = rsm_rst_n & core_rst_n & ~sw_full_rst;
        clr_n_vec[2] = rsm_rst_n;
        clr_n_vec[3] = rsm_rst_n;
    end

    pm_lock_field #(
        .LOCK_W (LOCK_W)
    ) u_lock (
        .clk        (clk),
        .clr_n      (rsm_rst_n & ~sw_full_rst),
        .wr_i       (wr_hit),
        .wdata_i    (reg_wdata[LOCK_W-1:0]),
        .ovr_en_i   (lock_ovr_en),
        .ovr_code_i (lock_ovr_code),
        .field_o    (lock_field),
        .eff_o      (lock_sel_o)
    );

    pm_rtc_pgood_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_pgood (
        .clk       (clk),
        .rtc_clk   (rtc_clk),
        .rsm_rst_n (rsm_rst_n),
        .pgood_i   (vrm_pgood),
        .fall_o    (pgood_fall)
    );

    for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
        pm_sticky_flag #(
            .CLR_ON_ONE (CLR_ONE_MASK[i])
        ) u_flag (
            .clk      (clk),
            .clr_n    (clr_n_vec[i]),
            .set_i    (set_vec[i]),
            .wr_i     (wr_hit),
            .wr_bit_i (reg_wdata[FLAG_LSB+i]),
            .flag_o   (flag_vec[i])
        );
    end

    // Pack the read value; unused upper bits read zero.
    always_comb begin
        reg_rdata                          = '0;
        reg_rdata[LOCK_W-1:0]              = lock_field;
        reg_rdata[USED_W-1:FLAG_LSB]       = flag_vec;
    end

endmodule

// File: rtl/pm_status_bank_chk.sv
// Property checker for the status bank, attached with bind. Observes only
// the ports of the bank; flag positions follow the packed register layout.
module pm_status_bank_chk (
    input logic       clk,
    input logic       rsm_rst_n,
    input logic       core_rst_n,
    input logic       sw_full_rst,
    input logic       reg_sel,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       rst_button,
    input logic       plt_rst_n,
    input logic       therm_trip,
    input logic [2:0] sleep_state,
    input logic       width_viol
);

    logic wr_hit;
    logic trip_ok;
    assign wr_hit  = reg_wr & reg_sel;
    assign trip_ok = plt_rst_n & therm_trip & (sleep_state <= 3'd1);

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        (!wr_hit && !sw_full_rst) |=> $stable(reg_rdata[1:0])); // R2

    AST_BTN_SET: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        (rst_button && !sw_full_rst) |=> reg_rdata[2]); // R4

    AST_THERM_SET: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        (trip_ok && core_rst_n && !sw_full_rst) |=> reg_rdata[3]); // R5

    AST_THERM_NOSET: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        (!reg_rdata[3] && !trip_ok) |=> !reg_rdata[3]); // R5

    AST_WIDTH_SET: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        width_viol |=> reg_rdata[4]); // R7

    AST_SUPPLY_HOLD: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        (reg_rdata[5] && !(wr_hit && !reg_wdata[5])) |=> reg_rdata[5]); // R8

    AST_BTN_SURVIVE_CORE: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        (reg_rdata[2] && !wr_hit && !sw_full_rst) |=> reg_rdata[2]); // R4

endmodule

bind pm_status_bank pm_status_bank_chk u_chk (
    .clk         (clk),
    .rsm_rst_n   (rsm_rst_n),
    .core_rst_n  (core_rst_n),
    .sw_full_rst (sw_full_rst),
    .reg_sel     (reg_sel),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .rst_button  (rst_button),
    .plt_rst_n   (plt_rst_n),
    .therm_trip  (therm_trip),
    .sleep_state (sleep_state),
    .width_viol  (width_viol)
);

// File: tb/pm_status_bank_tb.sv
// Bench: behavioural reference model compared on every clock, plus
// directed checks at the corner cases.
module pm_status_bank_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SYNC_N     = 3;

    logic       clk = 1'b0;
    logic       rtc_clk = 1'b0;
    logic       rsm_rst_n = 1'b0;
    logic       core_rst_n = 1'b0;
    logic       sw_full_rst = 1'b0;
    logic       reg_sel = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       lock_ovr_en = 1'b0;
    logic [1:0] lock_ovr_code = 2'd0;
    logic [1:0] lock_sel_o;
    logic       rst_button = 1'b0;
    logic       plt_rst_n = 1'b0;
    logic       therm_trip = 1'b0;
    logic [2:0] sleep_state = 3'd0;
    logic       width_viol = 1'b0;
    logic       vrm_pgood = 1'b1;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    pm_status_bank #(
        .REG_W (8), .LOCK_W (2), .SYNC_STAGES (SYNC_N)
    ) u_dut (
        .clk (clk), .rtc_clk (rtc_clk), .rsm_rst_n (rsm_rst_n),
        .core_rst_n (core_rst_n), .sw_full_rst (sw_full_rst),
        .reg_sel (reg_sel), .reg_wr (reg_wr), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata), .lock_ovr_en (lock_ovr_en),
        .lock_ovr_code (lock_ovr_code), .lock_sel_o (lock_sel_o),
        .rst_button (rst_button), .plt_rst_n (plt_rst_n),
        .therm_trip (therm_trip), .sleep_state (sleep_state),
        .width_viol (width_viol), .vrm_pgood (vrm_pgood)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    initial begin
        #3;
        forever #(CLK_PERIOD*4) rtc_clk = ~rtc_clk;
    end

    // Reference model state.
    int m_lock = 0;
    bit m_btn = 0, m_th = 0, m_wd = 0, m_sf = 0;
    bit m_rtc = 1;
    bit hist[$];

    initial for (int k = 0; k <= SYNC_N; k++) hist.push_back(1'b1);

    always @(posedge rtc_clk) m_rtc = rsm_rst_n ? vrm_pgood : 1'b1;

    always @(posedge clk) begin
        bit wr, awake, fall;
        wr    = reg_wr && reg_sel;
        awake = (sleep_state == 3'd0) || (sleep_state == 3'd1);
        if (!rsm_rst_n) begin
            m_lock = 0; m_btn = 0; m_th = 0; m_wd = 0; m_sf = 0;
            for (int k = 0; k <= SYNC_N; k++) hist[k] = 1'b1;
        end else begin
            fall = hist[SYNC_N] && !hist[SYNC_N-1];
            if (sw_full_rst) m_lock = 0;
            else if (wr) m_lock = int'(reg_wdata[1:0]);
            if (sw_full_rst) m_btn = 0;
            else if (rst_button) m_btn = 1;
            else if (wr && reg_wdata[2]) m_btn = 0;
            if (sw_full_rst || !core_rst_n) m_th = 0;
            else if (plt_rst_n && therm_trip && awake) m_th = 1;
            else if (wr && reg_wdata[3]) m_th = 0;
            if (width_viol) m_wd = 1;
            else if (wr && reg_wdata[4]) m_wd = 0;
            if (fall && awake) m_sf = 1;
            else if (wr && !reg_wdata[5]) m_sf = 0;
            hist.push_front(m_rtc);
            void'(hist.pop_back());
        end
    end

    task automatic cmp(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison, away from the edge.
    always @(posedge clk) begin
        #2;
        if (!done) begin
            cmp("R2 lock field", int'(reg_rdata[1:0]), m_lock);
            cmp("R3 effective lock", int'(lock_sel_o), lock_ovr_en ? int'(lock_ovr_code) : m_lock);
            cmp("R4 button flag", int'(reg_rdata[2]), int'(m_btn));
            cmp("R5 thermal flag", int'(reg_rdata[3]), int'(m_th));
            cmp("R7 width flag", int'(reg_rdata[4]), int'(m_wd));
            cmp("R8 supply flag", int'(reg_rdata[5]), int'(m_sf));
            cmp("R11 unused bits", int'(reg_rdata[7:6]), 0);
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic pulse_full;
        @(negedge clk); sw_full_rst = 1'b1;
        @(negedge clk); sw_full_rst = 1'b0;
    endtask

    task automatic pulse_core;
        @(negedge clk); core_rst_n = 1'b0;
        @(negedge clk); core_rst_n = 1'b1;
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cycles(30);
        rsm_rst_n = 1'b1; core_rst_n = 1'b1; plt_rst_n = 1'b1;
        cycles(2);
        cmp("R1 reset read", int'(reg_rdata), 0);
        cmp("R1 reset lock sel", int'(lock_sel_o), 0);

        // R2: write, core reset keeps, full reset clears.
        wr_reg(8'h03);
        cmp("R2 write lock", int'(reg_rdata[1:0]), 3);
        pulse_core(); cycles(1);
        cmp("R2 core reset keeps lock", int'(reg_rdata[1:0]), 3);
        pulse_full(); cycles(1);
        cmp("R2 full reset clears lock", int'(reg_rdata[1:0]), 0);
        wr_reg(8'h02);

        // R3: override.
        @(negedge clk); lock_ovr_en = 1'b1; lock_ovr_code = 2'd1;
        cycles(1);
        cmp("R3 override output", int'(lock_sel_o), 1);
        cmp("R3 override leaves field", int'(reg_rdata[1:0]), 2);
        @(negedge clk); lock_ovr_en = 1'b0;
        cycles(1);
        cmp("R3 no override output", int'(lock_sel_o), 2);

        // R4: button flag.
        @(negedge clk); rst_button = 1'b1;
        @(negedge clk); rst_button = 1'b0;
        cmp("R4 button set", int'(reg_rdata[2]), 1);
        pulse_core(); cycles(1);
        cmp("R4 button survives core reset", int'(reg_rdata[2]), 1);
        wr_reg(8'h06);
        cmp("R4 button W1C", int'(reg_rdata[2]), 0);
        @(negedge clk); rst_button = 1'b1;
        @(negedge clk); rst_button = 1'b0;
        pulse_full(); cycles(1);
        cmp("R4 button full reset", int'(reg_rdata[2]), 0);

        // R5: thermal set conditions.
        @(negedge clk); plt_rst_n = 1'b0; therm_trip = 1'b1;
        cycles(3);
        cmp("R5 no set in platform reset", int'(reg_rdata[3]), 0);
        @(negedge clk); plt_rst_n = 1'b1; sleep_state = 3'd3;
        cycles(3);
        cmp("R5 no set in S3", int'(reg_rdata[3]), 0);
        @(negedge clk); sleep_state = 3'd1;
        cycles(1);
        cmp("R5 set in S1", int'(reg_rdata[3]), 1);
        @(negedge clk); therm_trip = 1'b0; sleep_state = 3'd0;
        wr_reg(8'h08);
        cmp("R5 thermal W1C", int'(reg_rdata[3]), 0);

        // R6: thermal survives platform reset, cleared by core reset.
        @(negedge clk); therm_trip = 1'b1;
        @(negedge clk); therm_trip = 1'b0; plt_rst_n = 1'b0;
        cycles(4);
        @(negedge clk); plt_rst_n = 1'b1;
        cmp("R6 thermal survives platform reset", int'(reg_rdata[3]), 1);
        pulse_core(); cycles(1);
        cmp("R6 thermal core reset", int'(reg_rdata[3]), 0);

        // R7: width flag.
        @(negedge clk); width_viol = 1'b1;
        @(negedge clk); width_viol = 1'b0;
        pulse_core(); pulse_full(); cycles(1);
        cmp("R7 width survives core and full", int'(reg_rdata[4]), 1);
        wr_reg(8'h10);
        cmp("R7 width W1C", int'(reg_rdata[4]), 0);

        // R8: supply failure.
        @(negedge clk); sleep_state = 3'd3; vrm_pgood = 1'b0;
        cycles(30);
        @(negedge clk); vrm_pgood = 1'b1;
        cycles(30);
        cmp("R8 no set outside S0/S1", int'(reg_rdata[5]), 0);
        @(negedge clk); sleep_state = 3'd0; vrm_pgood = 1'b0;
        cycles(30);
        @(negedge clk); vrm_pgood = 1'b1;
        cycles(20);
        cmp("R8 supply set", int'(reg_rdata[5]), 1);
        wr_reg(8'h20);
        cmp("R8 write 1 keeps", int'(reg_rdata[5]), 1);
        pulse_core(); pulse_full(); cycles(1);
        cmp("R8 survives core and full", int'(reg_rdata[5]), 1);
        wr_reg(8'h00);
        cmp("R8 write 0 clears", int'(reg_rdata[5]), 0);

        // R9: short glitch between slow-clock samples.
        @(posedge rtc_clk);
        @(negedge clk); vrm_pgood = 1'b0;
        cycles(3);
        @(negedge clk); vrm_pgood = 1'b1;
        cycles(30);
        cmp("R9 glitch ignored", int'(reg_rdata[5]), 0);

        // R10: set beats clear in the same cycle.
        @(negedge clk);
        rst_button = 1'b1; width_viol = 1'b1;
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 8'h14;
        @(negedge clk);
        rst_button = 1'b0; width_viol = 1'b0;
        reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = 8'h00;
        cmp("R10 button set wins", int'(reg_rdata[2]), 1);
        cmp("R10 width set wins", int'(reg_rdata[4]), 1);

        // R12: unselected write.
        @(negedge clk); reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h3F;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = 8'h00;
        cmp("R12 unselected write", int'(reg_rdata), 8'h14);

        // R11: upper bits stay zero.
        wr_reg(8'hFF);
        cmp("R11 upper bits zero", int'(reg_rdata[7:6]), 0);
        cmp("R11 lock after full write", int'(reg_rdata[1:0]), 3);

        // R1: resume-well reset clears everything.
        @(negedge clk); width_viol = 1'b1;
        @(negedge clk); width_viol = 1'b0; rsm_rst_n = 1'b0;
        cycles(20);
        @(negedge clk); rsm_rst_n = 1'b1;
        cycles(1);
        cmp("R1 resume reset read", int'(reg_rdata), 0);
        cycles(5);
        finish_run();
    end

endmodule